// File: doc/BRIEF.md
# Packed ADC Capture Ring Writer

This block takes raw 20-bit conversions from a multichannel ADC and stores them in a 64 KiB circular buffer in on-chip memory. A pacing counter, loaded through a register write port, starts a scan every programmed number of clock periods. The block then accepts one sample per channel, lowest channel first. The samples are packed with no gaps into a bit stream. The stream is cut into 16-bit halfwords, and each halfword goes out on a memory write port.

One scan of 32 samples fills exactly 640 bits, which is 40 halfwords or 80 bytes. A 16-bit pointer counts halfwords and shows software where the next write will land. It moves only after the last halfword of a frame has been written, so a reader polling it never sees part of a frame. A scan request that comes while a frame is still being collected or written is dropped, and a sticky overrun flag records the loss.

Top module: `adc_ring_packer`

## Requirements
- R1: After synchronous reset the pointer is 0, and `mem_we`, `scan_start` and `overrun` are all 0.
- R2: With an interval value N of 2 or more and the block idle, `scan_start` pulses exactly N cycles apart. A write to the interval register restarts the count, so the first pulse comes N cycles after the write edge.
- R3: Interval values 0 and 1 both request a scan on every cycle. A scan is admitted on the first cycle that is not busy, which is the cycle after the final halfword of the previous frame appears on the write port.
- R4: Packing is little-endian. Sample i of a scan (channel i, the i-th sample accepted after `scan_start`) occupies frame bits [20i+19:20i]. Halfword k of the frame carries frame bits [16k+15:16k].
- R5: Halfwords are written to consecutive halfword addresses modulo 32768, starting from address 0 after reset.
- R6: `wr_ptr` holds the next halfword address. It changes only in the cycle after the 40th halfword of a frame appears on the write port, and it then becomes the address that follows that halfword.
- R7: A `smp_valid` outside an active scan is ignored, whether it comes before `scan_start` or after the 32nd sample. Such a sample causes no write and no pointer change.
- R8: A scan request that comes while a frame is being collected or drained gives no `scan_start` and sets `overrun`, which stays set until reset. Every frame written is exactly 40 halfwords.
- R9: A frame may straddle the end of the buffer. Halfword address 32767 is followed by address 0 inside the frame, and the pointer wraps with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_wr | input | 1 | Write strobe for the scan interval register |
| interval_data | input | 32 | Scan interval in clock periods |
| scan_start | output | 1 | One-cycle pulse that starts a scan in the front end |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 20 | Raw conversion result |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | 15 | Buffer halfword address |
| mem_wdata | output | 16 | Buffer halfword data |
| wr_ptr | output | 16 | Published next-halfword pointer |
| overrun | output | 1 | Sticky lost-scan flag |

## Verification
The assertions assume that the front end never raises `smp_valid` on two consecutive cycles. This spacing keeps the packing accumulator within 35 bits. They also assume that the front end supplies samples only in answer to `scan_start`. The stimulus keeps to both rules by presenting each sample for one cycle and then leaving a gap. The stray samples in the test for R7 also follow the same every-other-cycle spacing. Programmed intervals are either long enough for a frame to drain, or 0 and 1, where dropped requests are the behaviour under test.

// File: rtl/arp_pkg.sv
package arp_pkg;
   // Number of memory words filled by one scan.
   function automatic int words_per_frame(input int sample_w, input int chans, input int word_w);
      return (sample_w * chans) / word_w;
   endfunction

   // Scan interval applied at reset, in clock periods.
   localparam int unsigned ARP_RESET_INTERVAL = 99000;
endpackage

// File: rtl/arp_pacer.sv
module arp_pacer #(
   parameter int CNT_W = 32,
   parameter int unsigned RESET_INTERVAL = 99000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_wr,
   input  logic [CNT_W-1:0] cfg_data,
   output logic             tick
);
   logic [CNT_W-1:0] interval_q;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] terminal;

   // Values 0 and 1 both give a tick on every cycle.
   always_comb begin
      if (interval_q <= CNT_W'(1)) terminal = '0;
      else                         terminal = interval_q - CNT_W'(1);
   end

   assign tick = (count_q >= terminal);

   always_ff @(posedge clk) begin
      if (rst) begin
         interval_q <= CNT_W'(RESET_INTERVAL);
         count_q    <= '0;
      end else if (cfg_wr) begin
         interval_q <= cfg_data;
         count_q    <= '0;
      end else if (tick) begin
         count_q    <= '0;
      end else begin
         count_q    <= count_q + CNT_W'(1);
      end
   end

   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
      (tick && interval_q > CNT_W'(1) && !cfg_wr) |=> !tick);
endmodule

// File: rtl/arp_bit_packer.sv
module arp_bit_packer #(
   parameter int SAMPLE_W = 20,
   parameter int WORD_W   = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                out_valid,
   output logic [WORD_W-1:0]   out_data,
   output logic                empty
);
   // Residue before a sample is below WORD_W, so this width always suffices.
   localparam int ACC_W = SAMPLE_W + WORD_W;
   localparam int LVL_W = $clog2(ACC_W + 1);

   logic [ACC_W-1:0] acc_q, acc_base, acc_ins;
   logic [LVL_W-1:0] lvl_q, lvl_base;
   logic             emit;

   assign emit = (lvl_q >= LVL_W'(WORD_W));

   always_comb begin
      acc_base = emit ? (acc_q >> WORD_W) : acc_q;
      lvl_base = emit ? (lvl_q - LVL_W'(WORD_W)) : lvl_q;
      acc_ins  = ACC_W'(in_data) << lvl_base;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         lvl_q <= '0;
      end else if (in_valid) begin
         acc_q <= acc_base | acc_ins;
         lvl_q <= lvl_base + LVL_W'(SAMPLE_W);
      end else begin
         acc_q <= acc_base;
         lvl_q <= lvl_base;
      end
   end

   assign out_valid = emit;
   assign out_data  = acc_q[WORD_W-1:0];
   assign empty     = (lvl_q == '0);

   // Input contract: a gap after every sample.
   assert_sample_spacing_R4: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> !in_valid);
   assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
      lvl_q < LVL_W'(ACC_W));
endmodule

// File: rtl/arp_ring_writer.sv
module arp_ring_writer #(
   parameter int WORD_W      = 16,
   parameter int ADDR_W      = 15,
   parameter int PTR_W       = 16,
   parameter int FRAME_WORDS = 40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic [PTR_W-1:0]  wr_ptr
);
   localparam int IDX_W = $clog2(FRAME_WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

   logic [ADDR_W-1:0] next_addr_q;
   logic [ADDR_W-1:0] pub_q;
   logic [IDX_W-1:0]  idx_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         next_addr_q <= '0;
         idx_q       <= '0;
         mem_we      <= 1'b0;
         mem_addr    <= '0;
         mem_wdata   <= '0;
         last_q      <= 1'b0;
         pub_q       <= '0;
      end else begin
         mem_we <= wr_valid;
         if (wr_valid) begin
            mem_addr    <= next_addr_q;
            mem_wdata   <= wr_data;
            last_q      <= (idx_q == LAST_IDX);
            next_addr_q <= next_addr_q + ADDR_W'(1);
            idx_q       <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
         end
         // Publish one cycle after the closing halfword is on the port.
         if (mem_we && last_q) pub_q <= mem_addr + ADDR_W'(1);
      end
   end

   generate
      if (PTR_W > ADDR_W) begin : g_ptr_pad
         assign wr_ptr = {{(PTR_W - ADDR_W){1'b0}}, pub_q};
      end else begin : g_ptr_direct
         assign wr_ptr = pub_q;
      end
   endgenerate

   assert_ptr_on_frame_R6: assert property (@(posedge clk) disable iff (rst)
      (pub_q != $past(pub_q)) |-> $past(mem_we && last_q));
   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
      (pub_q != $past(pub_q)) |-> (pub_q == $past(pub_q) + ADDR_W'(FRAME_WORDS)));
endmodule

// File: rtl/adc_ring_packer.sv
module adc_ring_packer #(
   parameter int SAMPLE_W  = 20,
   parameter int CHANNELS  = 32,
   parameter int WORD_W    = 16,
   parameter int BUF_BYTES = 65536,
   parameter int PTR_W     = 16,
   parameter int CNT_W     = 32,
   parameter int unsigned RESET_INTERVAL = arp_pkg::ARP_RESET_INTERVAL
) (
   input  logic                                    clk,
   input  logic                                    rst,
   input  logic                                    interval_wr,
   input  logic [CNT_W-1:0]                        interval_data,
   output logic                                    scan_start,
   input  logic                                    smp_valid,
   input  logic [SAMPLE_W-1:0]                     smp_data,
   output logic                                    mem_we,
   output logic [$clog2(BUF_BYTES*8/WORD_W)-1:0]   mem_addr,
   output logic [WORD_W-1:0]                       mem_wdata,
   output logic [PTR_W-1:0]                        wr_ptr,
   output logic                                    overrun
);
   localparam int FRAME_WORDS = arp_pkg::words_per_frame(SAMPLE_W, CHANNELS, WORD_W);
   localparam int BUF_WORDS   = BUF_BYTES * 8 / WORD_W;
   localparam int ADDR_W      = $clog2(BUF_WORDS);
   localparam int SCNT_W      = $clog2(CHANNELS);

   generate
      if ((SAMPLE_W * CHANNELS) % WORD_W != 0) begin : g_bad_frame
         $error("a scan must fill a whole number of words");
      end
      if ((1 << ADDR_W) != BUF_WORDS) begin : g_bad_depth
         $error("buffer depth in words must be a power of two");
      end
      if (PTR_W < ADDR_W) begin : g_bad_ptr
         $error("pointer narrower than buffer address");
      end
      if (SAMPLE_W > 2 * WORD_W || SAMPLE_W < WORD_W) begin : g_bad_ratio
         $error("sample width must lie between one and two words");
      end
   endgenerate

   logic              tick;
   logic              scan_active_q;
   logic [SCNT_W-1:0] smp_cnt_q;
   logic              accept;
   logic              pk_valid;
   logic [WORD_W-1:0] pk_data;
   logic              pk_empty;
   logic              busy;

   arp_pacer #(.CNT_W(CNT_W), .RESET_INTERVAL(RESET_INTERVAL)) pacer_i (
      .clk(clk), .rst(rst), .cfg_wr(interval_wr), .cfg_data(interval_data), .tick(tick));

   assign busy   = scan_active_q | ~pk_empty;
   assign accept = scan_active_q & smp_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         scan_start    <= 1'b0;
         scan_active_q <= 1'b0;
         smp_cnt_q     <= '0;
         overrun       <= 1'b0;
      end else begin
         scan_start <= tick & ~busy;
         if (tick && !busy) begin
            scan_active_q <= 1'b1;
            smp_cnt_q     <= '0;
         end else if (accept) begin
            smp_cnt_q <= smp_cnt_q + SCNT_W'(1);
            if (smp_cnt_q == SCNT_W'(CHANNELS - 1)) scan_active_q <= 1'b0;
         end
         if (tick && busy) overrun <= 1'b1;
      end
   end

   arp_bit_packer #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) packer_i (
      .clk(clk), .rst(rst), .in_valid(accept), .in_data(smp_data),
      .out_valid(pk_valid), .out_data(pk_data), .empty(pk_empty));

   arp_ring_writer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W),
                     .FRAME_WORDS(FRAME_WORDS)) writer_i (
      .clk(clk), .rst(rst), .wr_valid(pk_valid), .wr_data(pk_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr));

   assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      $past(overrun) |-> overrun);
   assert_start_when_drained_R8: assert property (@(posedge clk) disable iff (rst)
      scan_start |-> $past(pk_empty));
   assert_no_write_idle_R7: assert property (@(posedge clk) disable iff (rst)
      (!scan_active_q && pk_empty) |=> !pk_valid);
endmodule

// File: tb/adc_ring_packer_tb_top.sv
module adc_ring_packer_tb_top;
   localparam int SW = 20;
   localparam int CH = 32;
   localparam int FB = SW * CH;
   localparam int FW = FB / 16;
   localparam int BW = 32768;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        interval_wr = 1'b0;
   logic [31:0] interval_data = '0;
   logic        scan_start;
   logic        smp_valid = 1'b0;
   logic [19:0] smp_data = '0;
   logic        mem_we;
   logic [14:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] wr_ptr;
   logic        overrun;

   int n_cmp = 0, n_bad = 0;
   int mon_idx = 0, frames_done = 0, drv_frame = 0, extra_n = 0;
   bit drv_en = 1'b1, ptr_due = 1'b0, saw_wrap = 1'b0, done = 1'b0;
   logic [15:0] last_ptr = '0, exp_ptr = '0;

   always #5 clk = ~clk;

   adc_ring_packer dut_i (
      .clk(clk), .rst(rst), .interval_wr(interval_wr), .interval_data(interval_data),
      .scan_start(scan_start), .smp_valid(smp_valid), .smp_data(smp_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .wr_ptr(wr_ptr), .overrun(overrun));

   function automatic logic [19:0] sval(input int f, input int i);
      int t;
      t = (f * 32 + i) * 40503 + f * 7;
      return t[19:0];
   endfunction

   function automatic logic [15:0] exp_hw(input int idx);
      logic [FB-1:0] bits;
      int f;
      f = idx / FW;
      for (int i = 0; i < CH; i++) bits[SW*i +: SW] = sval(f, i);
      return bits[16*(idx % FW) +: 16];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic set_interval(input logic [31:0] v);
      interval_data = v;
      interval_wr = 1'b1;
      @(negedge clk);
      interval_wr = 1'b0;
   endtask

   // Front end model: answers each scan_start with channel-ordered samples.
   initial begin
      forever begin
         @(negedge clk);
         if (drv_en && scan_start && !done) begin
            int total;
            total = CH + extra_n;
            for (int i = 0; i < total; i++) begin
               smp_valid = 1'b1;
               smp_data  = (i < CH) ? sval(drv_frame, i) : 20'hFFFFF;
               @(negedge clk);
               smp_valid = 1'b0;
               if (i != total - 1) @(negedge clk);
            end
            drv_frame++;
         end
      end
   end

   // Write port and pointer monitor (R4, R5, R6, R9).
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && !done) begin
            if (ptr_due) begin
               check("R6 pointer after frame", 32'(wr_ptr), 32'(exp_ptr));
               ptr_due = 1'b0;
            end else if (wr_ptr !== last_ptr) begin
               check("R6 pointer stable mid-frame", 32'(wr_ptr), 32'(last_ptr));
            end
            last_ptr = wr_ptr;
            if (mem_we) begin
               check("R5 halfword address", 32'(mem_addr), 32'(mon_idx % BW));
               check("R4 packed halfword", 32'(mem_wdata), 32'(exp_hw(mon_idx)));
               if (mon_idx == BW && mem_addr == 15'd0) saw_wrap = 1'b1;
               mon_idx++;
               if (mon_idx % FW == 0) begin
                  ptr_due = 1'b1;
                  frames_done++;
                  exp_ptr = 16'(mon_idx % BW);
               end
            end
         end
      end
   end

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1 pointer at reset", 32'(wr_ptr), 0);
      check("R1 write enable at reset", 32'(mem_we), 0);
      check("R1 scan_start at reset", 32'(scan_start), 0);
      check("R1 overrun at reset", 32'(overrun), 0);
   endtask

   task automatic t_pacing();
      int n;
      @(negedge clk);
      set_interval(32'd150);
      n = 1;
      while (!scan_start) begin @(negedge clk); n++; end
      check("R2 first scan after interval write", 32'(n), 32'd151);
      for (int k = 0; k < 2; k++) begin
         n = 0;
         do begin @(negedge clk); n++; end while (!scan_start);
         check("R2 scan spacing", 32'(n), 32'd150);
      end
   endtask

   task automatic t_stray();
      int w0, f0;
      logic [15:0] p0;
      set_interval(32'd5000);
      repeat (100) @(negedge clk);
      drv_en = 1'b0;
      w0 = mon_idx;
      p0 = wr_ptr;
      for (int i = 0; i < 4; i++) begin
         smp_valid = 1'b1; smp_data = 20'h5A5A5;
         @(negedge clk);
         smp_valid = 1'b0;
         @(negedge clk);
      end
      repeat (10) @(negedge clk);
      check("R7 no write from stray samples", 32'(mon_idx), 32'(w0));
      check("R7 pointer unchanged by stray samples", 32'(wr_ptr), 32'(p0));
      drv_en = 1'b1;
      extra_n = 3;
      f0 = frames_done;
      set_interval(32'd100);
      while (frames_done < f0 + 2) @(negedge clk);
      extra_n = 0;
      repeat (2) @(negedge clk);
      check("R7 surplus samples dropped, pointer", 32'(wr_ptr), 32'((frames_done * FW) % BW));
      check("R7 no partial frame", 32'(mon_idx % FW), 0);
   endtask

   task automatic t_back_to_back();
      int w;
      set_interval(32'd5000);
      repeat (150) @(negedge clk);
      check("R8 overrun clear before flood", 32'(overrun), 0);
      set_interval(32'd1);
      @(negedge clk);
      check("R3 interval 1 scan next cycle", 32'(scan_start), 1);
      @(negedge clk);
      check("R8 overrun on busy request", 32'(overrun), 1);
      w = 0;
      while (w < FW) begin @(negedge clk); if (mem_we) w++; end
      @(negedge clk);
      check("R3 interval 1 scan right after drain", 32'(scan_start), 1);
      set_interval(32'd0);
      w = 0;
      while (w < FW) begin @(negedge clk); if (mem_we) w++; end
      @(negedge clk);
      check("R3 interval 0 scan right after drain", 32'(scan_start), 1);
      check("R8 overrun stays set", 32'(overrun), 1);
   endtask

   task automatic t_wrap();
      while (frames_done < 821) @(negedge clk);
      set_interval(32'd5000);
      repeat (200) @(negedge clk);
      check("R9 address wrapped inside a frame", 32'(saw_wrap), 1);
      check("R9 pointer after wrap", 32'(wr_ptr), 32'((frames_done * FW) % BW));
      check("R8 whole frames only", 32'(mon_idx % FW), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_pacing();
      t_stray();
      t_back_to_back();
      t_wrap();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule